// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small, fully associative store of page translations. Each slot keeps a virtual page tag, a physical page number, an 8-bit address space number, a global flag, read and write enable masks with one bit per privilege mode, and two trap bits: one for reads and one for writes. A lookup presents a virtual page number and the current address space number. In the same cycle the block returns whether a slot matched, which slot it was, and the contents of that slot. A slot matches when the tags are equal and the slot is either global or owned by the requested address space.

New translations are written through an insert port. Each insert goes to the slot named by a round-robin victim pointer. Whatever that slot held before is overwritten, and the pointer then moves on by one. A flush command port offers three operations:
- Wipe the whole store.
- Drop every non-global slot, for example on a process switch.
- Drop the slots that one page would match.

A flush and an insert never both take effect in the same cycle; the flush wins. Permission checking, fault generation and table walking are done by the logic around the block.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is set or whose stored address space number equals `lk_asn`.
- R2: On a miss, `lk_hit` is 0 and `lk_idx`, `lk_ppn`, `lk_asn_out`, `lk_global`, `lk_rd_en`, `lk_wr_en`, `lk_trap_rd` and `lk_trap_wr` are all 0.
- R3: When several slots hit, `lk_idx` and the returned fields belong to the lowest-numbered hitting slot.
- R4: An accepted insert is visible to lookups from the next cycle. It writes the slot named by the victim pointer, with tag `ins_vaddr[VA_W-1:PAGE_SHIFT]`, the supplied fields, and the valid flag set. The offset bits `ins_vaddr[PAGE_SHIFT-1:0]` play no part.
- R5: Each accepted insert advances the victim pointer by one, wrapping from ENTRIES-1 to 0. Whatever the target slot held before is lost.
- R6: `fl_cmd` = 2'b01 invalidates every slot and returns the victim pointer to 0.
- R7: `fl_cmd` = 2'b10 invalidates every non-global slot and leaves global slots valid.
- R8: `fl_cmd` = 2'b11 invalidates every slot that a lookup with `fl_vpn` and `fl_asn` would hit, and leaves all other slots intact.
- R9: While `fl_cmd` is non-zero, `ins_en` is ignored: no slot is written, and the 2'b10 and 2'b11 commands leave the victim pointer where it was.
- R10: After reset every slot is invalid and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_vpn | input | VA_W-PAGE_SHIFT | Virtual page number to translate |
| lk_asn | input | ASN_W | Current address space number |
| lk_hit | output | 1 | A slot matched |
| lk_idx | output | $clog2(ENTRIES) | Index of the matching slot |
| lk_ppn | output | PPN_W | Physical page number of the matching slot |
| lk_asn_out | output | ASN_W | Stored address space number |
| lk_global | output | 1 | Stored global flag |
| lk_rd_en | output | MODES | Read enable per privilege mode |
| lk_wr_en | output | MODES | Write enable per privilege mode |
| lk_trap_rd | output | 1 | Trap-on-read flag |
| lk_trap_wr | output | 1 | Trap-on-write flag |
| ins_en | input | 1 | Insert request |
| ins_vaddr | input | VA_W | Virtual address; the page field becomes the tag |
| ins_ppn | input | PPN_W | Physical page number to store |
| ins_asn | input | ASN_W | Address space number to store |
| ins_global | input | 1 | Global flag to store |
| ins_rd_en | input | MODES | Read enable mask to store |
| ins_wr_en | input | MODES | Write enable mask to store |
| ins_trap_rd | input | 1 | Trap-on-read flag to store |
| ins_trap_wr | input | 1 | Trap-on-write flag to store |
| fl_cmd | input | 2 | 00 none, 01 all, 10 non-global, 11 by page |
| fl_vpn | input | VA_W-PAGE_SHIFT | Page number for the by-page flush |
| fl_asn | input | ASN_W | Address space number for the by-page flush |

## Verification
Several properties are checked on every cycle:
- After a lookup, the returned index names a hitting slot with no lower hitting slot, and a miss returns all-zero fields.
- An accepted insert leaves its slot valid and carrying the new tag.
- A non-global flush spares global slots and kills the others.
- The pointer steps with wrap on each accepted insert, stays put under a partial flush, and returns to 0 with empty contents after a full flush.

Some behaviour only the bench scenarios can show:
- The address space match with and without the global flag.
- A by-page flush that removes an owned slot and a global slot but spares a slot owned by another address space.
- Eviction after the pointer wraps.
- Whether an insert issued alongside a flush really left no trace.

// File: rtl/asn_tlb_pkg.sv
package asn_tlb_pkg;

   typedef enum logic [1:0] {
      FLUSH_NONE  = 2'b00,
      FLUSH_ALL   = 2'b01,
      FLUSH_LOCAL = 2'b10,
      FLUSH_PAGE  = 2'b11
   } flush_op_e;

endpackage

// File: rtl/tlb_slot.sv
module tlb_slot #(
   parameter int TAG_W = 30,
   parameter int ASN_W = 8,
   parameter int PAY_W = 38
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             wr_i,
   input  logic             inv_local_i,
   input  logic             inv_page_i,
   input  logic [TAG_W-1:0] wr_tag_i,
   input  logic [ASN_W-1:0] wr_asn_i,
   input  logic             wr_glb_i,
   input  logic [PAY_W-1:0] wr_pay_i,
   input  logic [TAG_W-1:0] lk_tag_i,
   input  logic [ASN_W-1:0] lk_asn_i,
   input  logic [TAG_W-1:0] fl_tag_i,
   input  logic [ASN_W-1:0] fl_asn_i,
   output logic             vld_o,
   output logic             hit_o,
   output logic [ASN_W-1:0] asn_o,
   output logic             glb_o,
   output logic [PAY_W-1:0] pay_o
);

   logic             vld_q;
   logic [TAG_W-1:0] tag_q;
   logic [ASN_W-1:0] asn_q;
   logic             glb_q;
   logic [PAY_W-1:0] pay_q;
   logic             fl_match;

   assign fl_match = vld_q && (tag_q == fl_tag_i) && (glb_q || (asn_q == fl_asn_i));
   assign hit_o    = vld_q && (tag_q == lk_tag_i) && (glb_q || (asn_q == lk_asn_i));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         tag_q <= '0;
         asn_q <= '0;
         glb_q <= 1'b0;
         pay_q <= '0;
      end else if (clr_i) begin
         vld_q <= 1'b0;
         tag_q <= '0;
         asn_q <= '0;
         glb_q <= 1'b0;
         pay_q <= '0;
      end else if (wr_i) begin
         vld_q <= 1'b1;
         tag_q <= wr_tag_i;
         asn_q <= wr_asn_i;
         glb_q <= wr_glb_i;
         pay_q <= wr_pay_i;
      end else if (inv_local_i && !glb_q) begin
         vld_q <= 1'b0;
      end else if (inv_page_i && fl_match) begin
         vld_q <= 1'b0;
      end
   end

   assign vld_o = vld_q;
   assign asn_o = asn_q;
   assign glb_o = glb_q;
   assign pay_o = pay_q;

   // R4
   insert_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !clr_i) |=> (vld_q && tag_q == $past(wr_tag_i)));

   // R7
   local_keeps_global_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_local_i && !wr_i && !clr_i && vld_q && glb_q) |=> vld_q);

   // R7
   local_kills_private_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inv_local_i && !wr_i && !glb_q) |=> !vld_q);

endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int N = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);

   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec_i[i]) idx_o = IW'(i);
      end
   end

   assign any_o = |vec_i;

endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
   parameter int N = 16,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          adv_i,
   output logic [IW-1:0] ptr_o
);

   localparam logic [IW-1:0] LAST = IW'(N - 1);

   logic [IW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= '0;
      else if (clr_i)    ptr_q <= '0;
      else if (adv_i)    ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
   end

   assign ptr_o = ptr_q;

   // R5
   ptr_step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !clr_i) |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

   // R5
   ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= LAST);

endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
   import asn_tlb_pkg::*;
#(
   parameter int ENTRIES    = 16,
   parameter int VA_W       = 43,
   parameter int PAGE_SHIFT = 13,
   parameter int PPN_W      = 28,
   parameter int ASN_W      = 8,
   parameter int MODES      = 4
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [VA_W-PAGE_SHIFT-1:0]   lk_vpn,
   input  logic [ASN_W-1:0]             lk_asn,
   output logic                         lk_hit,
   output logic [$clog2(ENTRIES)-1:0]   lk_idx,
   output logic [PPN_W-1:0]             lk_ppn,
   output logic [ASN_W-1:0]             lk_asn_out,
   output logic                         lk_global,
   output logic [MODES-1:0]             lk_rd_en,
   output logic [MODES-1:0]             lk_wr_en,
   output logic                         lk_trap_rd,
   output logic                         lk_trap_wr,
   input  logic                         ins_en,
   input  logic [VA_W-1:0]              ins_vaddr,
   input  logic [PPN_W-1:0]             ins_ppn,
   input  logic [ASN_W-1:0]             ins_asn,
   input  logic                         ins_global,
   input  logic [MODES-1:0]             ins_rd_en,
   input  logic [MODES-1:0]             ins_wr_en,
   input  logic                         ins_trap_rd,
   input  logic                         ins_trap_wr,
   input  logic [1:0]                   fl_cmd,
   input  logic [VA_W-PAGE_SHIFT-1:0]   fl_vpn,
   input  logic [ASN_W-1:0]             fl_asn
);

   localparam int TAG_W = VA_W - PAGE_SHIFT;
   localparam int IW    = $clog2(ENTRIES);
   localparam int PAY_W = PPN_W + 2 * MODES + 2;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("asn_tlb: ENTRIES must be at least 2");
   end
   if (PAGE_SHIFT < 1 || PAGE_SHIFT >= VA_W) begin : g_bad_shift
      $error("asn_tlb: PAGE_SHIFT must lie inside the virtual address");
   end
   if (ASN_W < 1 || MODES < 1 || PPN_W < 1) begin : g_bad_fields
      $error("asn_tlb: field widths must be positive");
   end

   flush_op_e fl_op;
   logic      take_ins, do_all, do_local, do_page;
   logic [IW-1:0]    ptr;
   logic [TAG_W-1:0] ins_tag;
   logic [PAY_W-1:0] ins_pay;
   logic             unused_ofs;

   assign fl_op      = flush_op_e'(fl_cmd);
   assign do_all     = (fl_op == FLUSH_ALL);
   assign do_local   = (fl_op == FLUSH_LOCAL);
   assign do_page    = (fl_op == FLUSH_PAGE);
   assign take_ins   = ins_en && (fl_op == FLUSH_NONE);
   assign ins_tag    = ins_vaddr[VA_W-1:PAGE_SHIFT];
   assign unused_ofs = ^ins_vaddr[PAGE_SHIFT-1:0];
   assign ins_pay    = {ins_ppn, ins_rd_en, ins_wr_en, ins_trap_rd, ins_trap_wr};

   logic [ENTRIES-1:0] hit_vec, vld_vec;
   logic [PAY_W-1:0]   pay_a [ENTRIES];
   logic [ASN_W-1:0]   asn_a [ENTRIES];
   logic [ENTRIES-1:0] glb_vec;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
      tlb_slot #(.TAG_W(TAG_W), .ASN_W(ASN_W), .PAY_W(PAY_W)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .clr_i       (do_all),
         .wr_i        (take_ins && (ptr == IW'(g))),
         .inv_local_i (do_local),
         .inv_page_i  (do_page),
         .wr_tag_i    (ins_tag),
         .wr_asn_i    (ins_asn),
         .wr_glb_i    (ins_global),
         .wr_pay_i    (ins_pay),
         .lk_tag_i    (lk_vpn),
         .lk_asn_i    (lk_asn),
         .fl_tag_i    (fl_vpn),
         .fl_asn_i    (fl_asn),
         .vld_o       (vld_vec[g]),
         .hit_o       (hit_vec[g]),
         .asn_o       (asn_a[g]),
         .glb_o       (glb_vec[g]),
         .pay_o       (pay_a[g])
      );
   end

   tlb_rr_ptr #(.N(ENTRIES)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (do_all),
      .adv_i (take_ins),
      .ptr_o (ptr)
   );

   logic          any_hit;
   logic [IW-1:0] first_idx;

   tlb_first_hit #(.N(ENTRIES)) u_enc (
      .vec_i (hit_vec),
      .any_o (any_hit),
      .idx_o (first_idx)
   );

   logic [PAY_W-1:0] sel_pay;

   always_comb begin
      sel_pay    = '0;
      lk_asn_out = '0;
      lk_global  = 1'b0;
      if (any_hit) begin
         sel_pay    = pay_a[first_idx];
         lk_asn_out = asn_a[first_idx];
         lk_global  = glb_vec[first_idx];
      end
   end

   assign lk_hit = any_hit;
   assign lk_idx = first_idx;
   assign {lk_ppn, lk_rd_en, lk_wr_en, lk_trap_rd, lk_trap_wr} = sel_pay;

   // R3
   lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (hit_vec[lk_idx] && ((hit_vec & ~({ENTRIES{1'b1}} << lk_idx)) == '0)));

   // R2
   miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_idx == '0 && lk_ppn == '0 && lk_rd_en == '0 && lk_wr_en == '0
                   && !lk_trap_rd && !lk_trap_wr && !lk_global && lk_asn_out == '0));

   // R6
   flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      do_all |=> (vld_vec == '0 && ptr == '0));

   // R9
   partial_flush_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (do_local || do_page) |=> $stable(ptr));

endmodule

// File: tb/asn_tlb_tb.sv
`timescale 1ns/1ps
module asn_tlb_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [29:0] lk_vpn = '0;
   logic [7:0]  lk_asn = '0;
   logic        lk_hit;
   logic [3:0]  lk_idx;
   logic [27:0] lk_ppn;
   logic [7:0]  lk_asn_out;
   logic        lk_global;
   logic [3:0]  lk_rd_en, lk_wr_en;
   logic        lk_trap_rd, lk_trap_wr;
   logic        ins_en = 1'b0;
   logic [42:0] ins_vaddr = '0;
   logic [27:0] ins_ppn = '0;
   logic [7:0]  ins_asn = '0;
   logic        ins_global = 1'b0;
   logic [3:0]  ins_rd_en = '0, ins_wr_en = '0;
   logic        ins_trap_rd = 1'b0, ins_trap_wr = 1'b0;
   logic [1:0]  fl_cmd = 2'b00;
   logic [29:0] fl_vpn = '0;
   logic [7:0]  fl_asn = '0;

   int compared = 0;
   int mismatched = 0;

   always #2 clk = ~clk;

   asn_tlb u_dut (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_hit(lk_hit), .lk_idx(lk_idx),
      .lk_ppn(lk_ppn), .lk_asn_out(lk_asn_out), .lk_global(lk_global),
      .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
      .lk_trap_rd(lk_trap_rd), .lk_trap_wr(lk_trap_wr),
      .ins_en(ins_en), .ins_vaddr(ins_vaddr), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
      .ins_global(ins_global), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
      .ins_trap_rd(ins_trap_rd), .ins_trap_wr(ins_trap_wr),
      .fl_cmd(fl_cmd), .fl_vpn(fl_vpn), .fl_asn(fl_asn)
   );

   localparam logic [2:0] OP_LK = 3'd0, OP_INS = 3'd1, OP_FA = 3'd2, OP_FP = 3'd3, OP_FV = 3'd4;

   typedef struct packed {
      logic [2:0]  op;
      logic [29:0] vpn;
      logic [7:0]  asn;
      logic        glb;
      logic        hit;
      logic [3:0]  idx;
      logic [27:0] ppn;
   } step_t;

   localparam int NSTEP = 27;
   localparam step_t STEPS [NSTEP] = '{
      '{OP_LK,  30'h100, 8'd1, 1'b0, 1'b0, 4'd0, 28'h0},    // R10 empty after reset, R2
      '{OP_INS, 30'h100, 8'd1, 1'b0, 1'b0, 4'd0, 28'hAAA},  // slot 0
      '{OP_INS, 30'h200, 8'd2, 1'b1, 1'b0, 4'd0, 28'hBBB},  // slot 1 global
      '{OP_INS, 30'h100, 8'd3, 1'b0, 1'b0, 4'd0, 28'hCCC},  // slot 2
      '{OP_LK,  30'h100, 8'd1, 1'b0, 1'b1, 4'd0, 28'hAAA},  // R1 R4
      '{OP_LK,  30'h100, 8'd3, 1'b0, 1'b1, 4'd2, 28'hCCC},  // R1
      '{OP_LK,  30'h100, 8'd5, 1'b0, 1'b0, 4'd0, 28'h0},    // R1 asn mismatch
      '{OP_LK,  30'h200, 8'd9, 1'b0, 1'b1, 4'd1, 28'hBBB},  // R1 global
      '{OP_INS, 30'h300, 8'd1, 1'b1, 1'b0, 4'd0, 28'hDDD},  // slot 3 global
      '{OP_INS, 30'h100, 8'd7, 1'b1, 1'b0, 4'd0, 28'hEEE},  // slot 4 global
      '{OP_LK,  30'h100, 8'd1, 1'b0, 1'b1, 4'd0, 28'hAAA},  // R3 slots 0,4
      '{OP_LK,  30'h100, 8'd3, 1'b0, 1'b1, 4'd2, 28'hCCC},  // R3 slots 2,4
      '{OP_LK,  30'h100, 8'd9, 1'b0, 1'b1, 4'd4, 28'hEEE},  // R1 global only
      '{OP_FV,  30'h100, 8'd3, 1'b0, 1'b0, 4'd0, 28'h0},    // R8 kills 2 and 4
      '{OP_LK,  30'h100, 8'd3, 1'b0, 1'b0, 4'd0, 28'h0},    // R8
      '{OP_LK,  30'h100, 8'd1, 1'b0, 1'b1, 4'd0, 28'hAAA},  // R8 other asn kept
      '{OP_LK,  30'h300, 8'd4, 1'b0, 1'b1, 4'd3, 28'hDDD},  // R8 other tag kept
      '{OP_FP,  30'h0,   8'd0, 1'b0, 1'b0, 4'd0, 28'h0},    // R7
      '{OP_LK,  30'h100, 8'd1, 1'b0, 1'b0, 4'd0, 28'h0},    // R7 private gone
      '{OP_LK,  30'h200, 8'd2, 1'b0, 1'b1, 4'd1, 28'hBBB},  // R7 global kept
      '{OP_LK,  30'h300, 8'd1, 1'b0, 1'b1, 4'd3, 28'hDDD},  // R7 global kept
      '{OP_INS, 30'h400, 8'd0, 1'b0, 1'b0, 4'd0, 28'h111},  // R9 ptr still 5
      '{OP_LK,  30'h400, 8'd0, 1'b0, 1'b1, 4'd5, 28'h111},  // R9 R5
      '{OP_FA,  30'h0,   8'd0, 1'b0, 1'b0, 4'd0, 28'h0},    // R6
      '{OP_LK,  30'h200, 8'd2, 1'b0, 1'b0, 4'd0, 28'h0},    // R6 global gone
      '{OP_INS, 30'h500, 8'd0, 1'b0, 1'b0, 4'd0, 28'h222},  // R6 ptr back to 0
      '{OP_LK,  30'h500, 8'd0, 1'b0, 1'b1, 4'd0, 28'h222}   // R6
   };

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   task automatic cmp(input logic [63:0] act, input logic [63:0] exp, input string req, input string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic do_insert(input logic [29:0] vpn, input logic [7:0] asn,
                            input logic glb, input logic [27:0] ppn, input logic [1:0] fl);
      @(negedge clk);
      ins_en      = 1'b1;
      ins_vaddr   = {vpn, 13'h1A5};
      ins_asn     = asn;
      ins_global  = glb;
      ins_ppn     = ppn;
      ins_rd_en   = vpn[3:0];
      ins_wr_en   = vpn[7:4];
      ins_trap_rd = vpn[8];
      ins_trap_wr = vpn[9];
      fl_cmd      = fl;
      @(negedge clk);
      ins_en = 1'b0;
      fl_cmd = 2'b00;
   endtask

   task automatic do_flush(input logic [1:0] cmd, input logic [29:0] vpn, input logic [7:0] asn);
      @(negedge clk);
      fl_cmd = cmd;
      fl_vpn = vpn;
      fl_asn = asn;
      @(negedge clk);
      fl_cmd = 2'b00;
   endtask

   task automatic lookup(input logic [29:0] vpn, input logic [7:0] asn, input logic eh,
                         input logic [3:0] ei, input logic [27:0] ep, input string req);
      @(negedge clk);
      lk_vpn = vpn;
      lk_asn = asn;
      #1;
      cmp(64'(lk_hit), 64'(eh), req, "hit");
      cmp(64'(lk_idx), 64'(ei), req, "idx");
      cmp(64'(lk_ppn), 64'(ep), req, "ppn");
      if (eh) begin
         cmp(64'({lk_rd_en, lk_wr_en, lk_trap_rd, lk_trap_wr}),
             64'({vpn[3:0], vpn[7:4], vpn[8], vpn[9]}), req, "modes/traps");
      end else begin
         // R2 all fields zero on a miss
         cmp(64'({lk_rd_en, lk_wr_en, lk_trap_rd, lk_trap_wr, lk_global, lk_asn_out}), 64'd0,
             "R2", "miss fields");
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      mismatched++;
      $display("FAIL all-requirements watchdog actual=timeout expected=completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state, checked while reset is still asserted
      #1;
      cmp(64'(lk_hit), 64'd0, "R10", "hit in reset");
      rst_n = 1'b1;

      for (int s = 0; s < NSTEP; s++) begin
         case (STEPS[s].op)
            OP_INS: do_insert(STEPS[s].vpn, STEPS[s].asn, STEPS[s].glb, STEPS[s].ppn, 2'b00);
            OP_FA:  do_flush(2'b01, STEPS[s].vpn, STEPS[s].asn);
            OP_FP:  do_flush(2'b10, STEPS[s].vpn, STEPS[s].asn);
            OP_FV:  do_flush(2'b11, STEPS[s].vpn, STEPS[s].asn);
            default: lookup(STEPS[s].vpn, STEPS[s].asn, STEPS[s].hit, STEPS[s].idx,
                            STEPS[s].ppn, $sformatf("R1/R3/R6/R7/R8 step %0d", s));
         endcase
      end

      // R5 wrap: pointer is at 1; 16 inserts fill slots 1..15 then slot 0
      for (int k = 0; k < 16; k++) begin
         do_insert(30'h1000 + 30'(k), 8'd4, 1'b0, 28'h7000 + 28'(k), 2'b00);
      end
      lookup(30'h500,  8'd0, 1'b0, 4'd0, 28'h0,    "R5 evicted");
      lookup(30'h100F, 8'd4, 1'b1, 4'd0, 28'h700F, "R5 wrapped to slot 0");
      lookup(30'h1000, 8'd4, 1'b1, 4'd1, 28'h7000, "R5 first of wrap");

      // R9 flush wins over a concurrent insert
      do_insert(30'h2000, 8'd4, 1'b1, 28'h999, 2'b10);
      lookup(30'h2000, 8'd4, 1'b0, 4'd0, 28'h0, "R9 insert ignored");
      lookup(30'h1000, 8'd4, 1'b0, 4'd0, 28'h0, "R9 flush applied");
      do_insert(30'h2001, 8'd4, 1'b0, 28'h998, 2'b00);
      lookup(30'h2001, 8'd4, 1'b1, 4'd1, 28'h998, "R9 pointer unchanged");

      // R4 offset bits irrelevant, tag from page field
      do_insert(30'h3000, 8'd6, 1'b0, 28'h3AB, 2'b00);
      lookup(30'h3000, 8'd6, 1'b1, 4'd2, 28'h3AB, "R4 tag from page field");

      report();
      $finish;
   end

endmodule